// File: doc/BRIEF.md
# Configurable ADC Serial Output Framer

This block turns the parallel samples of a two-channel data converter into serial lane streams. A frame clock and a double-data-rate bit clock go out beside the lanes. The whole block runs on one fast clock, and each cycle of that clock is one serial bit time. A sample strobe marks the cycle in which new samples for both channels are valid. After a strobe that starts or continues a stream, the block shifts the words out most-significant bit first.

The word width can be 14, 16, 18 or 20 bits. There are three lane arrangements:
- **Two-lane:** each channel is split across two lanes, and the frame clock covers two samples.
- **One-lane:** each channel has a lane of its own.
- **Shared:** both channels take turns on a single lane.

Requested width and arrangement are sampled continuously. They are adopted only while the framer is idle. If a change is pending when a frame ends, the stream stops, the lanes go quiet, and the next strobe starts the new format.

Top module: `adc_serial_framer`

## Requirements
- R1: While reset is high, and on the first cycle after it, all four lanes, the frame clock and the bit clock are low.
- R2: In one-lane mode (mode code 1, and also code 3), lane 0 carries channel A and lane 2 carries channel B, each MSB first, with W bits per sample. Lanes 1 and 3 stay low.
- R3: In two-lane mode (mode code 0), lanes 0 and 2 carry the upper W/2 bits of A and B, and lanes 1 and 3 carry the lower W/2 bits. Each is MSB first, and a sample lasts W/2 cycles.
- R4: In shared mode (mode code 2), lane 0 carries the W bits of A followed by the W bits of B, and a sample lasts 2W cycles. Lanes 1 to 3 stay low.
- R5: Width code c (0 to 3) selects W = 14 + 2c. Input bits at or above W have no effect on any lane.
- R6: The frame clock is high for the first ceil(F/2) bit times of each frame and low for the rest. F is W in two-lane and one-lane modes and 2W in shared mode. A two-lane frame spans two samples; other frames span one.
- R7: While streaming, the bit clock inverts every cycle. It is high on the first bit after a stream starts and low while idle.
- R8: A strobe is honoured only when idle or on the last bit of a sample; a strobe at any other time is ignored. If no strobe arrives on a sample's last bit, the block goes idle with all outputs low.
- R9: Requested width and mode take effect only while idle. On a frame's last bit, a pending change stops the stream even if a strobe is present, and that strobe is dropped.
- R10: A strobe while idle loads the samples, and the first bit appears on the lanes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe_i | input | 1 | Samples valid this cycle |
| ch_a_i | input | MAX_RES | Channel A sample, right-justified |
| ch_b_i | input | MAX_RES | Channel B sample, right-justified |
| res_sel_i | input | 2 | Requested width code |
| mode_sel_i | input | 2 | Requested lane mode code |
| lane_o | output | 4 | Serial lanes 0..3 |
| fclk_o | output | 1 | Frame clock |
| dclk_o | output | 1 | DDR bit clock |

## Verification
A sample boundary that carries a strobe can also be the end of a frame with a configuration request pending. In that cycle the continue decision and the reconfigure decision compete. The bench provokes it by changing width and mode halfway through a two-lane frame while the strobe cadence continues. The behavioural model then expects the second strobe of that frame to be honoured and the frame-end strobe to be dropped, with quiet lanes. It also expects the next strobe to restart in the new format, and the outputs are compared against the model on every cycle.

// File: rtl/asf_pkg.sv
package asf_pkg;

  typedef enum logic [1:0] {
    LM_TWO    = 2'd0,
    LM_ONE    = 2'd1,
    LM_SHARED = 2'd2,
    LM_SPARE  = 2'd3
  } lane_mode_e;

  function automatic int res_bits(input logic [1:0] code);
    return 14 + 2 * int'(code);
  endfunction

  function automatic int sample_len(input int res, input logic [1:0] mode);
    if (mode == LM_TWO)    return res / 2;
    if (mode == LM_SHARED) return 2 * res;
    return res;
  endfunction

  function automatic int frame_len(input int res, input logic [1:0] mode);
    if (mode == LM_SHARED) return 2 * res;
    return res;
  endfunction

endpackage

// File: rtl/asf_ctrl.sv
module asf_ctrl
  import asf_pkg::*;
#(
  parameter int MAX_RES = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_i,
  input  logic [1:0] req_res_i,
  input  logic [1:0] req_mode_i,
  output logic [1:0] cur_res_o,
  output logic [1:0] cur_mode_o,
  output logic       load_o,
  output logic       stop_o,
  output logic       run_o,
  output logic       fclk_o,
  output logic       dclk_o
);
  localparam int CW = $clog2(2 * MAX_RES + 1);

  logic          run_q, smp_q, fclk_q, dclk_q;
  logic [CW-1:0] bit_q, fpos_q, fpos_nx;
  logic [1:0]    act_res_q, act_mode_q, cur_res, cur_mode;
  logic [CW-1:0] slen, flen, fhi;
  logic          two_smp, end_sample, end_frame, cfg_diff, load, stop;

  always_comb begin
    cur_res    = run_q ? act_res_q  : req_res_i;
    cur_mode   = run_q ? act_mode_q : req_mode_i;
    slen       = CW'(sample_len(res_bits(cur_res), cur_mode));
    flen       = CW'(frame_len(res_bits(cur_res), cur_mode));
    fhi        = CW'((int'(flen) + 1) / 2);
    two_smp    = (cur_mode == LM_TWO);
    end_sample = run_q && (bit_q == slen - CW'(1));
    end_frame  = end_sample && (!two_smp || smp_q);
    cfg_diff   = {req_res_i, req_mode_i} != {act_res_q, act_mode_q};
    load       = strobe_i && (!run_q || (end_sample && !(end_frame && cfg_diff)));
    stop       = end_sample && !load;
    fpos_nx    = (load && (!run_q || end_frame)) ? '0 : fpos_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      smp_q      <= 1'b0;
      bit_q      <= '0;
      fpos_q     <= '0;
      fclk_q     <= 1'b0;
      dclk_q     <= 1'b0;
      act_res_q  <= '0;
      act_mode_q <= '0;
    end else begin
      if (!run_q) begin
        act_res_q  <= req_res_i;
        act_mode_q <= req_mode_i;
      end
      if (load) begin
        run_q  <= 1'b1;
        bit_q  <= '0;
        smp_q  <= (run_q && !end_frame);
        fpos_q <= fpos_nx;
        fclk_q <= (fpos_nx < fhi);
        dclk_q <= run_q ? ~dclk_q : 1'b1;
      end else if (stop) begin
        run_q  <= 1'b0;
        bit_q  <= '0;
        smp_q  <= 1'b0;
        fpos_q <= '0;
        fclk_q <= 1'b0;
        dclk_q <= 1'b0;
      end else if (run_q) begin
        bit_q  <= bit_q + CW'(1);
        fpos_q <= fpos_nx;
        fclk_q <= (fpos_nx < fhi);
        dclk_q <= ~dclk_q;
      end
    end
  end

  assign cur_res_o  = cur_res;
  assign cur_mode_o = cur_mode;
  assign load_o     = load;
  assign stop_o     = stop;
  assign run_o      = run_q;
  assign fclk_o     = fclk_q;
  assign dclk_o     = dclk_q;

  AST_DCLK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (run_q && !stop) |=> (dclk_q != $past(dclk_q))); // R7
  AST_DCLK_START: assert property (@(posedge clk) disable iff (rst)
    (load && !run_q) |=> dclk_q); // R7
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (!fclk_q && !dclk_q)); // R1
  AST_FRAME_HIGH: assert property (@(posedge clk) disable iff (rst)
    (load && (!run_q || end_frame)) |=> fclk_q); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> ($stable(act_res_q) && $stable(act_mode_q))); // R9

endmodule

// File: rtl/asf_lane.sv
module asf_lane
  import asf_pkg::*;
#(
  parameter int MAX_RES = 20,
  parameter int LANE    = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic               stop_i,
  input  logic               run_i,
  input  logic [1:0]         res_code_i,
  input  logic [1:0]         mode_i,
  input  logic [MAX_RES-1:0] ch_a_i,
  input  logic [MAX_RES-1:0] ch_b_i,
  output logic               lane_o
);
  localparam int SW        = 2 * MAX_RES;
  localparam bit USE_B     = (LANE / 2) == 1;
  localparam bit LOWER_SUB = (LANE % 2) == 1;

  logic [SW-1:0] sreg_q, word, a_tr, b_tr, chan, val, mask, hmask;
  int            res, half, len;

  always_comb begin
    res   = res_bits(res_code_i);
    half  = res / 2;
    mask  = (SW'(1) << res) - SW'(1);
    hmask = (SW'(1) << half) - SW'(1);
    a_tr  = SW'(ch_a_i) & mask;
    b_tr  = SW'(ch_b_i) & mask;
    chan  = USE_B ? b_tr : a_tr;
    val   = '0;
    len   = 1;
    case (mode_i)
      LM_TWO: begin
        len = half;
        val = LOWER_SUB ? (chan & hmask) : (chan >> half);
      end
      LM_SHARED: begin
        len = 2 * res;
        val = (LANE == 0) ? ((a_tr << res) | b_tr) : '0;
      end
      default: begin
        len = res;
        val = LOWER_SUB ? '0 : chan;
      end
    endcase
    word = val << (SW - len);
  end

  always_ff @(posedge clk) begin
    if (rst || stop_i)  sreg_q <= '0;
    else if (load_i)    sreg_q <= word;
    else if (run_i)     sreg_q <= {sreg_q[SW-2:0], 1'b0};
  end

  assign lane_o = sreg_q[SW-1];

  AST_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> !lane_o); // R8

endmodule

// File: rtl/adc_serial_framer.sv
module adc_serial_framer
  import asf_pkg::*;
#(
  parameter int MAX_RES = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_strobe_i,
  input  logic [MAX_RES-1:0] ch_a_i,
  input  logic [MAX_RES-1:0] ch_b_i,
  input  logic [1:0]         res_sel_i,
  input  logic [1:0]         mode_sel_i,
  output logic [3:0]         lane_o,
  output logic               fclk_o,
  output logic               dclk_o
);
  localparam int NUM_LANES = 4;

  logic [1:0] cur_res, cur_mode;
  logic       load, stop, run;

  asf_ctrl #(.MAX_RES(MAX_RES)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .strobe_i   (smp_strobe_i),
    .req_res_i  (res_sel_i),
    .req_mode_i (mode_sel_i),
    .cur_res_o  (cur_res),
    .cur_mode_o (cur_mode),
    .load_o     (load),
    .stop_o     (stop),
    .run_o      (run),
    .fclk_o     (fclk_o),
    .dclk_o     (dclk_o)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    asf_lane #(.MAX_RES(MAX_RES), .LANE(g)) i_lane (
      .clk        (clk),
      .rst        (rst),
      .load_i     (load),
      .stop_i     (stop),
      .run_i      (run),
      .res_code_i (cur_res),
      .mode_i     (cur_mode),
      .ch_a_i     (ch_a_i),
      .ch_b_i     (ch_b_i),
      .lane_o     (lane_o[g])
    );
  end

endmodule

// File: tb/test_adc_serial_framer.sv
module test_adc_serial_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MR = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stb = 1'b0;
  logic [MR-1:0] da = '0, db = '0;
  logic [1:0]    rsel = 2'd0, msel = 2'd1;
  logic [3:0]    lane;
  logic          fclk, dclk;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  adc_serial_framer #(.MAX_RES(MR)) i_adc_serial_framer (
    .clk(clk), .rst(rst), .smp_strobe_i(stb), .ch_a_i(da), .ch_b_i(db),
    .res_sel_i(rsel), .mode_sel_i(msel), .lane_o(lane), .fclk_o(fclk), .dclk_o(dclk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit mq [4][$];
  bit m_run = 0, m_dclk = 0;
  int m_rem = 0, m_left = 0, m_fpos = 0, m_flen = 2;
  logic [1:0] m_ares = 0, m_amode = 0;

  function automatic int p_of(int res, logic [1:0] mode);
    if (mode == 2'd0) return res / 2;
    if (mode == 2'd2) return 2 * res;
    return res;
  endfunction

  task automatic fill(int res, logic [1:0] mode, logic [MR-1:0] a, logic [MR-1:0] b);
    for (int l = 0; l < 4; l++) mq[l].delete();
    if (mode == 2'd0) begin
      for (int i = res - 1; i >= res / 2; i--) begin mq[0].push_back(a[i]); mq[2].push_back(b[i]); end
      for (int i = res / 2 - 1; i >= 0; i--)   begin mq[1].push_back(a[i]); mq[3].push_back(b[i]); end
    end else if (mode == 2'd2) begin
      for (int i = res - 1; i >= 0; i--) mq[0].push_back(a[i]);
      for (int i = res - 1; i >= 0; i--) mq[0].push_back(b[i]);
    end else begin
      for (int i = res - 1; i >= 0; i--) begin mq[0].push_back(a[i]); mq[2].push_back(b[i]); end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_dclk = 0; m_rem = 0; m_fpos = 0; m_ares = 0; m_amode = 0;
      for (int l = 0; l < 4; l++) mq[l].delete();
    end else begin
      logic [1:0] cr, cm;
      int res, p, spf;
      bit at_end, fr_end, chg, ld;
      cr = m_run ? m_ares : rsel;
      cm = m_run ? m_amode : msel;
      res = 14 + 2 * int'(cr);
      p = p_of(res, cm);
      spf = (cm == 2'd0) ? 2 : 1;
      at_end = m_run && m_rem == 1;
      fr_end = at_end && m_left == 1;
      chg = (rsel != m_ares) || (msel != m_amode);
      ld = stb && (!m_run || (at_end && !(fr_end && chg)));
      if (!m_run) begin m_ares = rsel; m_amode = msel; end
      if (ld) begin
        if (!m_run || fr_end) begin m_fpos = 0; m_left = spf; end
        else begin m_fpos++; m_left--; end
        m_flen = (cm == 2'd2) ? 2 * res : res;
        m_rem = p;
        fill(res, cm, da, db);
        m_dclk = m_run ? !m_dclk : 1'b1;
        m_run = 1;
      end else if (at_end) begin
        m_run = 0; m_dclk = 0; m_fpos = 0;
        for (int l = 0; l < 4; l++) mq[l].delete();
      end else if (m_run) begin
        for (int l = 0; l < 4; l++) if (mq[l].size() > 0) void'(mq[l].pop_front());
        m_rem--; m_fpos++; m_dclk = !m_dclk;
      end
    end
  end

  task automatic chk(string t, string what, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b exp=%0b at cycle %0d", t, what, got, exp, cycles);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    cycles++;
    for (int l = 0; l < 4; l++)
      chk(tag, $sformatf("lane%0d", l), lane[l], (m_run && mq[l].size() > 0) ? mq[l][0] : 1'b0);
    chk("R6", "fclk", fclk, m_run && (m_fpos < (m_flen + 1) / 2));
    chk("R7", "dclk", dclk, m_dclk);
  end

  task automatic pulses(int n, int period);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      stb = 1'b1; da = MR'($urandom); db = MR'($urandom);
      @(negedge clk);
      stb = 1'b0;
      repeat (period - 2) @(negedge clk);
    end
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tag = "R2"; rsel = 2'd1; msel = 2'd1; pulses(4, 16); gap(20);
    msel = 2'd3; pulses(3, 16); gap(20);
    tag = "R3"; rsel = 2'd2; msel = 2'd0; pulses(6, 9); gap(12);
    tag = "R4"; rsel = 2'd0; msel = 2'd2; pulses(3, 28); gap(30);
    tag = "R5"; rsel = 2'd0; msel = 2'd1; pulses(3, 14); gap(15);
    rsel = 2'd3; msel = 2'd0; pulses(4, 10); gap(12);
    tag = "R8"; rsel = 2'd0; msel = 2'd1;
    @(negedge clk); stb = 1'b1; da = MR'($urandom); db = MR'($urandom);
    @(negedge clk); stb = 1'b0; gap(4);
    stb = 1'b1; da = MR'($urandom); @(negedge clk); stb = 1'b0;
    gap(30);
    tag = "R9"; rsel = 2'd1; msel = 2'd0;
    @(negedge clk); stb = 1'b1; da = MR'($urandom); db = MR'($urandom);
    @(negedge clk); stb = 1'b0; gap(3);
    rsel = 2'd3; msel = 2'd1; gap(3);
    pulses(3, 8); gap(10);
    pulses(3, 20); gap(25);
    tag = "R10"; rsel = 2'd2; msel = 2'd2; gap(7); pulses(2, 36); gap(40);
    tag = "R1"; rst = 1'b1; gap(3); rst = 1'b0; gap(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule